// File: doc/BRIEF.md
# Guided Random Instruction Word Generator

This block is a synthesizable stimulus source for processor verification. It emits one 32-bit base-integer instruction word per output handshake. Each word starts as the current value of a pseudorandom register. A programmable probability gate then decides whether a legal opcode, with its funct3 and funct7 bits where the format has them, is written over that word. A second, independent gate then decides whether one format-aware edit is applied. The possible edits are operand aliasing, a zeroed destination, a boundary immediate, or a supported CSR number. A tag travels with each word and names the edit that was actually applied, so that a downstream checker knows which corner case it is looking at.

Software-side loading of a seed restarts the pseudorandom sequence. A threshold load changes the two gate probabilities. The output is a valid/ready stream with these rules:
- While `out_valid` is high and `out_ready` is low, the word and tag do not change.
- The generator advances only when a word is accepted.
- A seed load discards any word that has not been accepted. `out_valid` is low for one cycle, and the next word is built from the new seed.

Top module: `guided_insn_gen`

## Requirements
- R1: `out_valid` is low while `rst_n` is low. After reset the word source holds 32'h00000001 and the gate thresholds are 250 (opcode) and 51 (edit). The first word appears one cycle after reset is released.
- R2: The word source is a 32-bit Galois LFSR. On each step the state shifts right by one. If the bit shifted out was 1, the result is XORed with 32'h80200003. Each accepted word moves the source one step.
- R3: `seed_load` sets the source to `seed_value`, or to 32'h1D872B41 when `seed_value` is zero. In the next cycle `out_valid` is low, and the following word is built from that seed.
- R4: While `out_valid` is high and `out_ready` is low, `out_word` and `out_tag` stay stable and the source does not advance.
- R5: An opcode is injected when an 8-bit random value is below the opcode threshold, so a threshold of 0 never injects. Without injection the word equals the source state. An injected encoding is one of the following:
  - LUI, AUIPC, JAL
  - JALR, LW, ADDI, SLTI, XORI
  - BEQ, BNE, BLT
  - SW
  - ADD, SUB
  - CSRRW, CSRRS (opcode 1110011 with funct3 001 and 010)

  Only bits [6:0], the funct3 bits [14:12] (not in U/J formats) and, for the R-type ADD/SUB, bits [31:25] are replaced; all other bits keep the source value.
- R6: An edit is considered only for an injected word, and only when a second 8-bit random value is below the edit threshold. An edit threshold of 0 makes every tag 0.
- R7: The codes on `out_tag` are:
  - 0 none
  - 1 rd forced to zero
  - 2 rd copied from rs1
  - 3 rd copied from rs2
  - 4 rs1 copied from rs2
  - 5 immediate MIN
  - 6 immediate -1
  - 7 immediate 0
  - 8 immediate 1
  - 9 immediate MAX
  - 10 CSR number

  Every code from 1 to 10 occurs.
- R8: The register edits act on the fields rd [11:7], rs1 [19:15] and rs2 [24:20]. They copy the source register value, and every bit that is not edited keeps its value.
- R9: An immediate edit writes the signed MIN, -1, 0, 1 or MAX of the format's encoded field: 12 bits for I, S and B; 20 bits for U and J. For B and J the field counts in 2-byte units, so the decoded offsets are -4096/-2/0/2/4094 and -1048576/-2/0/2/1048574.
- R10: A CSR edit sets bits [31:20] of a CSR instruction to one of 0x300, 0x301, 0x304, 0x305, 0x340, 0x341, 0x342 or 0x344.
- R11: The edits that each format accepts are:
  - rd zero: R, I, U, J, CSR
  - rd=rs1: R, I, CSR
  - rd=rs2: R only
  - rs1=rs2: R, S, B
  - immediates: I, S, B, U, J
  - CSR number: CSR only

  When the selected edit does not fit the format, the edit is dropped, the tag is 0 and the word is left unedited.
- R12: When `seed_load` and an accepted handshake fall in the same cycle, the accepted word counts as consumed and the seed load takes effect.
- R13: An ADDI with tag 2 has rd equal to rs1, and both equal the source rs1. Its immediate stays the source value.
- R14: A threshold load takes effect for words built after it. A word already waiting keeps the thresholds it was built with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed_value` into the random source and flush the pending word |
| seed_value | input | 32 | New seed; zero is replaced by a fixed constant |
| cfg_load | input | 1 | Load both gate thresholds |
| cfg_opc_thr | input | 8 | Opcode-injection threshold (out of 256) |
| cfg_mut_thr | input | 8 | Edit threshold (out of 256) |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 32 | Generated instruction word |
| out_tag | output | 4 | Edit applied to this word (R7 codes) |

## Verification
The interaction that matters most is a seed load landing in the same cycle as an accepted handshake. In that cycle the stream wants to advance while the reload wants to restart the source. The bench drives `out_ready` and `seed_load` on the same clock edge while a word is waiting. It then requires a single cycle with `out_valid` low, followed by a word equal to the new seed with neither the old word nor its successor reappearing. The gate tests use a reference LFSR in the bench to predict every raw word bit-for-bit. Each edited word is then rebuilt from that prediction and the tag, and compared field by field.

// File: rtl/gig_pkg.sv
package gig_pkg;
  localparam int XLEN       = 32;
  localparam int THR_W      = 8;
  localparam int TBL_SEL_W  = 4;
  localparam int KIND_SEL_W = 4;
  localparam int CSR_SEL_W  = 3;
  localparam int TAG_W      = 4;
  localparam int NUM_KINDS  = 10;

  // slices of the control random word
  localparam int OPC_GATE_LSB = 0;
  localparam int MUT_GATE_LSB = OPC_GATE_LSB + THR_W;
  localparam int TBL_LSB      = MUT_GATE_LSB + THR_W;
  localparam int KIND_LSB     = TBL_LSB + TBL_SEL_W;
  localparam int CSR_LSB      = KIND_LSB + KIND_SEL_W;

  typedef enum logic [2:0] {
    F_NONE, F_R, F_I, F_S, F_B, F_U, F_J, F_CSR
  } fmt_e;

  typedef enum logic [TAG_W-1:0] {
    MK_NONE     = 4'd0,
    MK_RD_ZERO  = 4'd1,
    MK_RD_RS1   = 4'd2,
    MK_RD_RS2   = 4'd3,
    MK_RS1_RS2  = 4'd4,
    MK_IMM_MIN  = 4'd5,
    MK_IMM_NEG1 = 4'd6,
    MK_IMM_ZERO = 4'd7,
    MK_IMM_ONE  = 4'd8,
    MK_IMM_MAX  = 4'd9,
    MK_CSR      = 4'd10
  } mut_e;

  typedef struct packed {
    logic [6:0] opcode;
    logic [2:0] f3;
    logic [6:0] f7;
    fmt_e       fmt;
  } enc_t;

  function automatic enc_t table_entry(input logic [TBL_SEL_W-1:0] idx);
    case (idx)
      4'd0:    return '{7'b0110111, 3'd0, 7'h00, F_U};
      4'd1:    return '{7'b0010111, 3'd0, 7'h00, F_U};
      4'd2:    return '{7'b1101111, 3'd0, 7'h00, F_J};
      4'd3:    return '{7'b1100111, 3'd0, 7'h00, F_I};
      4'd4:    return '{7'b1100011, 3'd0, 7'h00, F_B};
      4'd5:    return '{7'b1100011, 3'd1, 7'h00, F_B};
      4'd6:    return '{7'b1100011, 3'd4, 7'h00, F_B};
      4'd7:    return '{7'b0000011, 3'd2, 7'h00, F_I};
      4'd8:    return '{7'b0100011, 3'd2, 7'h00, F_S};
      4'd9:    return '{7'b0010011, 3'd0, 7'h00, F_I};
      4'd10:   return '{7'b0010011, 3'd2, 7'h00, F_I};
      4'd11:   return '{7'b0010011, 3'd4, 7'h00, F_I};
      4'd12:   return '{7'b0110011, 3'd0, 7'h00, F_R};
      4'd13:   return '{7'b0110011, 3'd0, 7'h20, F_R};
      4'd14:   return '{7'b1110011, 3'd1, 7'h00, F_CSR};
      default: return '{7'b1110011, 3'd2, 7'h00, F_CSR};
    endcase
  endfunction

  function automatic logic [11:0] csr_entry(input logic [CSR_SEL_W-1:0] idx);
    case (idx)
      3'd0:    return 12'h300;
      3'd1:    return 12'h301;
      3'd2:    return 12'h304;
      3'd3:    return 12'h305;
      3'd4:    return 12'h340;
      3'd5:    return 12'h341;
      3'd6:    return 12'h342;
      default: return 12'h344;
    endcase
  endfunction

  function automatic logic kind_fits(input fmt_e f, input mut_e k);
    case (k)
      MK_RD_ZERO:  return f inside {F_R, F_I, F_U, F_J, F_CSR};
      MK_RD_RS1:   return f inside {F_R, F_I, F_CSR};
      MK_RD_RS2:   return f == F_R;
      MK_RS1_RS2:  return f inside {F_R, F_S, F_B};
      MK_IMM_MIN, MK_IMM_NEG1, MK_IMM_ZERO, MK_IMM_ONE, MK_IMM_MAX:
                   return f inside {F_I, F_S, F_B, F_U, F_J};
      MK_CSR:      return f == F_CSR;
      default:     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gig_lfsr.sv
module gig_lfsr #(
  parameter int             W         = 32,
  parameter logic [W-1:0]   TAPS      = 32'h80200003,
  parameter logic [W-1:0]   RESET_VAL = 32'h00000001,
  parameter logic [W-1:0]   ZERO_SUB  = 32'h1D872B41
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         advance,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = st_q >> 1;
    if (st_q[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       st_q <= (RESET_VAL == '0) ? ZERO_SUB : RESET_VAL;
    else if (load)    st_q <= (load_val == '0) ? ZERO_SUB : load_val;
    else if (advance) st_q <= nxt;
  end

  assign state = st_q;
endmodule

// File: rtl/gig_opcode_inject.sv
module gig_opcode_inject
  import gig_pkg::*;
(
  input  logic [XLEN-1:0]      raw,
  input  logic                 en,
  input  logic [TBL_SEL_W-1:0] sel,
  output logic [XLEN-1:0]      word,
  output fmt_e                 fmt
);
  enc_t ent;

  always_comb begin
    ent  = table_entry(sel);
    word = raw;
    fmt  = F_NONE;
    if (en) begin
      fmt       = ent.fmt;
      word[6:0] = ent.opcode;
      if (!(ent.fmt inside {F_U, F_J})) word[14:12] = ent.f3;
      if (ent.fmt == F_R)               word[31:25] = ent.f7;
    end
  end
endmodule

// File: rtl/gig_field_mutate.sv
module gig_field_mutate
  import gig_pkg::*;
(
  input  logic [XLEN-1:0]       word_in,
  input  fmt_e                  fmt,
  input  logic                  en,
  input  logic [KIND_SEL_W-1:0] kind_sel,
  input  logic [CSR_SEL_W-1:0]  csr_sel,
  output logic [XLEN-1:0]       word_out,
  output logic [TAG_W-1:0]      tag
);
  localparam logic [KIND_SEL_W-1:0] NK = KIND_SEL_W'(NUM_KINDS);

  logic [KIND_SEL_W-1:0] kfold;
  mut_e                  kind;
  logic                  apply;
  logic                  narrow;
  logic [19:0]           fld;

  always_comb begin
    kfold  = (kind_sel >= NK) ? kind_sel - NK : kind_sel;
    kind   = mut_e'(TAG_W'(kfold) + TAG_W'(1));
    apply  = en && kind_fits(fmt, kind);
    narrow = fmt inside {F_I, F_S, F_B};
    case (kind)
      MK_IMM_MIN:  fld = narrow ? 20'h00800 : 20'h80000;
      MK_IMM_MAX:  fld = narrow ? 20'h007FF : 20'h7FFFF;
      MK_IMM_NEG1: fld = 20'hFFFFF;
      MK_IMM_ONE:  fld = 20'h00001;
      default:     fld = 20'h00000;
    endcase

    word_out = word_in;
    tag      = MK_NONE;
    if (apply) begin
      tag = kind;
      case (kind)
        MK_RD_ZERO: word_out[11:7]  = 5'd0;
        MK_RD_RS1:  word_out[11:7]  = word_in[19:15];
        MK_RD_RS2:  word_out[11:7]  = word_in[24:20];
        MK_RS1_RS2: word_out[19:15] = word_in[24:20];
        MK_CSR:     word_out[31:20] = csr_entry(csr_sel);
        default: begin
          case (fmt)
            F_I: word_out[31:20] = fld[11:0];
            F_S: begin
              word_out[31:25] = fld[11:5];
              word_out[11:7]  = fld[4:0];
            end
            F_B: begin
              word_out[31]    = fld[11];
              word_out[7]     = fld[10];
              word_out[30:25] = fld[9:4];
              word_out[11:8]  = fld[3:0];
            end
            F_U: word_out[31:12] = fld;
            F_J: begin
              word_out[31]    = fld[19];
              word_out[19:12] = fld[18:11];
              word_out[20]    = fld[10];
              word_out[30:21] = fld[9:0];
            end
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/guided_insn_gen.sv
module guided_insn_gen
  import gig_pkg::*;
#(
  parameter logic [XLEN-1:0]  RESET_SEED  = 32'h00000001,
  parameter logic [XLEN-1:0]  ZERO_SEED   = 32'h1D872B41,
  parameter logic [XLEN-1:0]  CTRL_SALT   = 32'h6C078965,
  parameter logic [XLEN-1:0]  CTRL_ALT    = 32'h2545F491,
  parameter logic [XLEN-1:0]  LFSR_TAPS   = 32'h80200003,
  parameter logic [THR_W-1:0] OPC_THR_RST = 8'd250,
  parameter logic [THR_W-1:0] MUT_THR_RST = 8'd51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [XLEN-1:0]  seed_value,
  input  logic             cfg_load,
  input  logic [THR_W-1:0] cfg_opc_thr,
  input  logic [THR_W-1:0] cfg_mut_thr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_word,
  output logic [TAG_W-1:0] out_tag
);
  logic [XLEN-1:0]  wstate, cstate, inj_word, mut_word;
  logic [THR_W-1:0] opc_thr_q, mut_thr_q;
  logic [TAG_W-1:0] mut_tag;
  fmt_e             inj_fmt;
  logic             inj_en, mut_en, fill, advance;
  logic             out_valid_q;
  logic [XLEN-1:0]  out_word_q;
  logic [TAG_W-1:0] out_tag_q;

  assign fill    = !out_valid_q || out_ready;
  assign advance = fill && !seed_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_thr_q <= OPC_THR_RST;
      mut_thr_q <= MUT_THR_RST;
    end else if (cfg_load) begin
      opc_thr_q <= cfg_opc_thr;
      mut_thr_q <= cfg_mut_thr;
    end
  end

  gig_lfsr #(.W(XLEN), .TAPS(LFSR_TAPS), .RESET_VAL(RESET_SEED), .ZERO_SUB(ZERO_SEED)) u_word_src (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .load_val(seed_value),
    .advance(advance), .state(wstate)
  );

  gig_lfsr #(.W(XLEN), .TAPS(LFSR_TAPS), .RESET_VAL(RESET_SEED ^ CTRL_SALT), .ZERO_SUB(CTRL_ALT)) u_ctrl_src (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .load_val(seed_value ^ CTRL_SALT),
    .advance(advance), .state(cstate)
  );

  assign inj_en = cstate[OPC_GATE_LSB +: THR_W] < opc_thr_q;
  assign mut_en = inj_en && (cstate[MUT_GATE_LSB +: THR_W] < mut_thr_q);

  gig_opcode_inject u_inject (
    .raw(wstate), .en(inj_en), .sel(cstate[TBL_LSB +: TBL_SEL_W]),
    .word(inj_word), .fmt(inj_fmt)
  );

  gig_field_mutate u_mutate (
    .word_in(inj_word), .fmt(inj_fmt), .en(mut_en),
    .kind_sel(cstate[KIND_LSB +: KIND_SEL_W]), .csr_sel(cstate[CSR_LSB +: CSR_SEL_W]),
    .word_out(mut_word), .tag(mut_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_word_q  <= '0;
      out_tag_q   <= '0;
    end else if (seed_load) begin
      out_valid_q <= 1'b0;
    end else if (fill) begin
      out_valid_q <= 1'b1;
      out_word_q  <= mut_word;
      out_tag_q   <= mut_tag;
    end
  end

  assign out_valid = out_valid_q;
  assign out_word  = out_word_q;
  assign out_tag   = out_tag_q;
endmodule

// File: rtl/guided_insn_gen_chk.sv
module guided_insn_gen_chk
  import gig_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_word,
  input logic [TAG_W-1:0] out_tag,
  input logic             fill,
  input logic [THR_W-1:0] opc_thr_q,
  input logic [THR_W-1:0] mut_thr_q,
  input logic [XLEN-1:0]  wstate
);
  always_ff @(posedge clk) begin
    if (rst_n) assert_src_nonzero_R2: assert (wstate != '0);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !seed_load) |=> (out_valid && $stable(out_word) && $stable(out_tag)));

  assert_seed_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !out_valid);

  assert_raw_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !seed_load && opc_thr_q == '0) |=> (out_word == $past(wstate) && out_tag == '0));

  assert_no_edit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !seed_load && mut_thr_q == '0) |=> out_tag == '0);

  assert_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == MK_RD_ZERO) |-> out_word[11:7] == 5'd0);

  assert_rd_rs1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == MK_RD_RS1) |-> out_word[11:7] == out_word[19:15]);

  assert_rs1_rs2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == MK_RS1_RS2) |-> out_word[19:15] == out_word[24:20]);

  assert_csr_pick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_tag == MK_CSR) |->
      (out_word[6:0] == 7'b1110011 &&
       out_word[31:20] inside {12'h300, 12'h301, 12'h304, 12'h305,
                               12'h340, 12'h341, 12'h342, 12'h344}));

  assert_tag_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tag <= 4'd10);
endmodule

bind guided_insn_gen guided_insn_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_tag(out_tag), .fill(fill),
  .opc_thr_q(opc_thr_q), .mut_thr_q(mut_thr_q), .wstate(wstate)
);

// File: tb/guided_insn_gen_tb.sv
module guided_insn_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TAPS  = 32'h80200003;
  localparam logic [31:0] ZSEED = 32'h1D872B41;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        seed_load = 1'b0, cfg_load = 1'b0, out_ready = 1'b0;
  logic [31:0] seed_value = '0;
  logic [7:0]  cfg_opc_thr = '0, cfg_mut_thr = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [3:0]  out_tag;

  int n_checks = 0, n_fail = 0;
  logic [31:0] model;

  guided_insn_gen u_dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .cfg_load(cfg_load), .cfg_opc_thr(cfg_opc_thr), .cfg_mut_thr(cfg_mut_thr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_tag(out_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lstep(input logic [31:0] s);
    logic [31:0] n = s >> 1;
    if (s[0]) n = n ^ TAPS;
    return n;
  endfunction

  // bench format codes: 0 none 1 R 2 I 3 S 4 B 5 U 6 J 7 CSR
  function automatic int fmt_of(input logic [6:0] op);
    case (op)
      7'b0110111, 7'b0010111:             return 5;
      7'b1101111:                         return 6;
      7'b1100111, 7'b0000011, 7'b0010011: return 2;
      7'b1100011:                         return 4;
      7'b0100011:                         return 3;
      7'b0110011:                         return 1;
      7'b1110011:                         return 7;
      default:                            return 0;
    endcase
  endfunction

  function automatic bit key_ok(input logic [31:0] w);
    case (w[6:0])
      7'b0110111, 7'b0010111, 7'b1101111: return 1'b1;
      7'b1100111: return w[14:12] == 3'd0;
      7'b1100011: return w[14:12] inside {3'd0, 3'd1, 3'd4};
      7'b0000011, 7'b0100011: return w[14:12] == 3'd2;
      7'b0010011: return w[14:12] inside {3'd0, 3'd2, 3'd4};
      7'b0110011: return w[14:12] == 3'd0 && w[31:25] inside {7'h00, 7'h20};
      7'b1110011: return w[14:12] inside {3'd1, 3'd2};
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] fix_mask(input int f);
    case (f)
      5, 6:    return 32'h0000007F;
      1:       return 32'hFE00707F;
      default: return 32'h0000707F;
    endcase
  endfunction

  function automatic logic [31:0] imm_mask(input int f);
    case (f)
      2:       return 32'hFFF00000;
      3, 4:    return 32'hFE000F80;
      default: return 32'hFFFFF000;
    endcase
  endfunction

  function automatic bit legal(input int f, input int t);
    case (t)
      1:       return f inside {1, 2, 5, 6, 7};
      2:       return f inside {1, 2, 7};
      3:       return f == 1;
      4:       return f inside {1, 3, 4};
      5, 6, 7, 8, 9: return f inside {2, 3, 4, 5, 6};
      10:      return f == 7;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int imm_of(input logic [31:0] w, input int f);
    logic signed [11:0] i12;
    logic signed [12:0] b13;
    logic signed [19:0] u20;
    logic signed [20:0] j21;
    i12 = w[31:20];
    case (f)
      2: return int'(i12);
      3: begin i12 = {w[31:25], w[11:7]}; return int'(i12); end
      4: begin b13 = {w[31], w[7], w[30:25], w[11:8], 1'b0}; return int'(b13); end
      5: begin u20 = w[31:12]; return int'(u20); end
      default: begin j21 = {w[31], w[19:12], w[20], w[30:21], 1'b0}; return int'(j21); end
    endcase
  endfunction

  function automatic int imm_exp(input int f, input int t);
    int half = (f inside {5, 6}) ? 524288 : 2048;
    int v;
    case (t)
      5:       v = -half;
      6:       v = -1;
      7:       v = 0;
      8:       v = 1;
      default: v = half - 1;
    endcase
    if (f inside {4, 6}) v = v * 2;
    return v;
  endfunction

  task automatic get_word(output logic [31:0] w, output logic [3:0] t);
    int waitc = 0;
    while (!out_valid && waitc < 8) begin
      @(negedge clk);
      waitc++;
    end
    chk(out_valid, "R4", "valid before accept", {31'd0, out_valid}, 32'd1);
    w = out_word;
    t = out_tag;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic load_cfg(input logic [7:0] o, input logic [7:0] m);
    cfg_opc_thr = o;
    cfg_mut_thr = m;
    cfg_load    = 1'b1;
    @(negedge clk);
    cfg_load    = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] s);
    seed_value = s;
    seed_load  = 1'b1;
    @(negedge clk);
    seed_load  = 1'b0;
    chk(!out_valid, "R3", "valid after seed load", {31'd0, out_valid}, 32'd0);
  endtask

  // full check of one edited/injected word against the reference raw word m
  bit tag_seen [0:10];
  bit addi_alias_seen = 1'b0;

  task automatic check_word(input logic [31:0] w, input logic [3:0] t, input logic [31:0] m);
    int f = fmt_of(w[6:0]);
    logic [31:0] e;
    tag_seen[t] = 1'b1;
    if (t == 4'd0) begin
      if (w != m) begin
        chk(f != 0 && key_ok(w), "R5", "injected encoding", w, m);
        chk(((w ^ m) & ~fix_mask(f)) == 0, "R5", "untouched bits", w, m);
      end else chk(1'b1, "R11", "raw word", w, m);
      return;
    end
    chk(f != 0 && key_ok(w), "R5", "edited word encoding", w, m);
    chk(legal(f, int'(t)), "R11", "edit fits format", {28'd0, t}, 32'(f));
    e = (m & ~fix_mask(f)) | (w & fix_mask(f));
    case (t)
      4'd1: e[11:7]  = 5'd0;
      4'd2: e[11:7]  = m[19:15];
      4'd3: e[11:7]  = m[24:20];
      4'd4: e[19:15] = m[24:20];
      default: ;
    endcase
    if (t <= 4'd4) begin
      chk(w == e, "R8", "register edit", w, e);
      if (t == 4'd2 && w[6:0] == 7'b0010011 && w[14:12] == 3'd0) begin
        addi_alias_seen = 1'b1;
        chk(w[11:7] == m[19:15] && w[19:15] == m[19:15] && w[31:20] == m[31:20],
            "R13", "addi rd=rs1", w, e);
      end
    end else if (t <= 4'd9) begin
      chk(imm_of(w, f) == imm_exp(f, int'(t)), "R9", "special immediate",
          32'(imm_of(w, f)), 32'(imm_exp(f, int'(t))));
      chk(((w ^ e) & ~imm_mask(f)) == 0, "R9", "bits beside immediate", w, e);
    end else begin
      chk(w[31:20] inside {12'h300, 12'h301, 12'h304, 12'h305,
                           12'h340, 12'h341, 12'h342, 12'h344},
          "R10", "csr number", {20'd0, w[31:20]}, 32'h300);
      chk(((w ^ e) & 32'h000FFFFF) == 0, "R10", "bits beside csr", w, e);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] w, held, old;
    logic [3:0]  t;
    int injected;

    // R1: reset
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", "valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid, "R1", "valid after reset", {31'd0, out_valid}, 32'd1);
    load_cfg(8'd0, 8'd0);
    get_word(w, t);                 // built with reset thresholds
    model = lstep(32'h00000001);
    get_word(w, t);
    chk(w == model, "R1", "second word from reset seed", w, model);
    chk(w == model, "R14", "new thresholds apply", w, model);
    model = lstep(model);

    // R2/R4/R6: raw sequence with back-pressure
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 7) begin
        held = out_word;
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          chk(out_word == held && out_valid, "R4", "hold under back-pressure", out_word, held);
        end
      end
      get_word(w, t);
      chk(w == model, "R2", "lfsr sequence", w, model);
      chk(t == 4'd0, "R6", "no edit at threshold 0", {28'd0, t}, 32'd0);
      model = lstep(model);
    end

    // R3: seed load and zero seed
    load_seed(32'hC0FFEE11);
    get_word(w, t);
    chk(w == 32'hC0FFEE11, "R3", "word from new seed", w, 32'hC0FFEE11);
    model = lstep(32'hC0FFEE11);
    for (int i = 0; i < 20; i++) begin
      get_word(w, t);
      chk(w == model, "R3", "sequence after seed", w, model);
      model = lstep(model);
    end
    load_seed(32'h0);
    get_word(w, t);
    chk(w == ZSEED, "R3", "zero seed substitute", w, ZSEED);
    model = lstep(ZSEED);

    // R12: seed load in the handshake cycle
    old        = out_word;
    out_ready  = 1'b1;
    seed_load  = 1'b1;
    seed_value = 32'h5EED0042;
    @(negedge clk);
    out_ready  = 1'b0;
    seed_load  = 1'b0;
    chk(!out_valid, "R12", "flush on collision", {31'd0, out_valid}, 32'd0);
    get_word(w, t);
    chk(w == 32'h5EED0042, "R12", "seed wins collision", w, 32'h5EED0042);
    chk(w != old && w != model, "R12", "old word not replayed", w, 32'h5EED0042);
    model = lstep(32'h5EED0042);

    // R14 + R5: opcode gate open, edits closed
    load_cfg(8'd255, 8'd0);
    get_word(w, t);
    chk(w == model, "R14", "pending word keeps old thresholds", w, model);
    model = lstep(model);
    injected = 0;
    for (int i = 0; i < 1500; i++) begin
      get_word(w, t);
      chk(t == 4'd0, "R6", "tag with edit threshold 0", {28'd0, t}, 32'd0);
      if (w != model) injected++;
      check_word(w, t, model);
      model = lstep(model);
    end
    chk(injected > 1350, "R5", "injection rate", 32'(injected), 32'd1350);

    // R7..R11, R13: both gates open
    for (int k = 0; k <= 10; k++) tag_seen[k] = 1'b0;
    load_cfg(8'd255, 8'd255);
    get_word(w, t);                 // built before the new thresholds
    check_word(w, t, model);
    model = lstep(model);
    for (int i = 0; i < 3000; i++) begin
      get_word(w, t);
      chk(t <= 4'd10, "R7", "tag code range", {28'd0, t}, 32'd10);
      check_word(w, t, model);
      model = lstep(model);
    end
    for (int k = 1; k <= 10; k++)
      chk(tag_seen[k], "R7", "tag code observed", 32'(k), 32'(k));
    chk(addi_alias_seen, "R13", "addi rd=rs1 observed", {31'd0, addi_alias_seen}, 32'd1);

    finish_run();
  end
endmodule